// File: doc/BRIEF.md
# CSI-2 RAW10 Pixel Repacking Bridge

This bridge sits behind a CSI-2 packet decoder and in front of a video pipeline. It receives long-packet payload on a 32-bit valid/ready bus. Each packet is marked by start and end flags and carries a data type code and a virtual channel tag as sideband. The bridge sends the data out as an AXI4-Stream video beat stream with two pixels per beat. TUSER marks the start of a frame and TLAST marks the end of a line.

A configuration input selects the one data type the downstream pipeline expects. Packets of that type are forwarded. RAW8 and the user-defined codes are always forwarded as well. Every other packet is consumed and discarded. When the configured type is RAW10, matching packets are converted from the CSI-2 packed layout into pixel-aligned 10-bit fields. All other forwarded packets are copied beat for beat.

Top module: `raw10_repack_bridge`

## Requirements
- R1: While reset (synchronous, active high) is held, and on the first cycle after it is released, `m_tvalid` is 0 and `s_ready` is 1.
- R2: A packet is forwarded when its type (taken on the beat with `s_sop`) equals `cfg_dt`, is 0x2A (RAW8), or lies in 0x30..0x37 (user-defined). Any other packet has all of its beats accepted and produces no output beat. For example, 0x2F and 0x38 are dropped unless configured.
- R3: With `cfg_dt` = 0x2B (RAW10), a matching packet is taken in beat pairs. On the first beat of a pair, byte k (bits 8k+7:8k) holds bits 9:2 of pixel k, for k = 0..3. On the second beat, bits 2k+1:2k hold bits 1:0 of pixel k, and bits 31:8 are ignored. The pair yields two output beats: pixels 0 and 1, then pixels 2 and 3. In each, the lower pixel sits on bits 9:0 and the higher on bits 19:10.
- R4: In every converted beat, `m_tdata` bits above 19 are 0.
- R5: A forwarded packet that is not converted produces exactly one output beat per input beat, with `m_tdata` equal to `s_data`.
- R6: `m_tlast` is 1 on the last output beat of each forwarded packet and 0 elsewhere. In a converted packet, this is the second output beat of the pair that carries `s_eop`.
- R7: In a converted packet whose `s_eop` falls on the first beat of a pair, that beat's pixel data is discarded. A single all-zero beat with `m_tlast` = 1 is emitted in its place.
- R8: `m_tuser` is 1 on the first output beat produced after a start beat with `s_fs` = 1 has been accepted, and 0 on all other beats. A frame-start flag seen on a dropped packet carries over to the next forwarded beat.
- R9: Every output beat carries, on `m_tdt` and `m_tvc`, the type and channel captured on its packet's start beat.
- R10: While `m_tvalid` is 1 and `m_tready` is 0, the output beat is held unchanged. `s_ready` is 0 while the second beat of a converted pair is waiting.
- R11: Reset discards a half-received pair, so a packet sent after reset converts as if nothing came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dt | input | DT_W | Configured data type code |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | IN_W | Input payload beat |
| s_sop | input | 1 | First beat of a packet |
| s_eop | input | 1 | Last beat of a packet |
| s_fs | input | 1 | Packet opens a frame (read with s_sop) |
| s_dt | input | DT_W | Packet data type (read with s_sop) |
| s_vc | input | VC_W | Packet virtual channel (read with s_sop) |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat taken |
| m_tdata | output | OUT_W | Output pixels or copied payload |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |
| m_tdt | output | DT_W | Data type of the beat's packet |
| m_tvc | output | VC_W | Virtual channel of the beat's packet |

## Verification
The properties take for granted that `cfg_dt` only changes while no beat is held inside the bridge. This is what lets the type filter and the zero upper bits be judged against the current configuration. They also assume packets are well formed: a start beat opens each packet, an end beat closes it, and an offered beat is held until it is accepted. The bench honours these assumptions. It drains the output before each configuration change, builds every packet from a complete start-to-end sequence, and keeps each beat on the bus until `s_ready` is seen.

// File: rtl/raw10br_pkg.sv
package raw10br_pkg;

   typedef enum logic [1:0] {
      MODE_DROP = 2'd0,
      MODE_PASS = 2'd1,
      MODE_CONV = 2'd2
   } mode_e;

   localparam logic [5:0] DT_RAW8    = 6'h2A;
   localparam logic [5:0] DT_RAW10   = 6'h2B;
   localparam logic [5:0] DT_USER_LO = 6'h30;
   localparam logic [5:0] DT_USER_HI = 6'h37;

endpackage

// File: rtl/raw10br_classify.sv
module raw10br_classify
   import raw10br_pkg::*;
#(
   parameter int DT_W = 6
) (
   input  logic [DT_W-1:0] pkt_dt,
   input  logic [DT_W-1:0] cfg_dt,
   output mode_e           mode
);

   logic exempt;

   // R2: RAW8 and the user-defined window are never filtered
   assign exempt = (pkt_dt == DT_W'(DT_RAW8)) ||
                   ((pkt_dt >= DT_W'(DT_USER_LO)) && (pkt_dt <= DT_W'(DT_USER_HI)));

   always_comb begin
      if (pkt_dt == cfg_dt)
         mode = (cfg_dt == DT_W'(DT_RAW10)) ? MODE_CONV : MODE_PASS;
      else if (exempt)
         mode = MODE_PASS;
      else
         mode = MODE_DROP;
   end

endmodule

// File: rtl/raw10br_unpack.sv
module raw10br_unpack #(
   parameter int GROUP  = 4,
   parameter int PIX_W  = 10,
   parameter int BYTE_W = 8,
   localparam int LSB_W = PIX_W - BYTE_W
) (
   input  logic [GROUP*BYTE_W-1:0] msb_word,
   input  logic [GROUP*LSB_W-1:0]  lsb_bits,
   output logic [GROUP*PIX_W-1:0]  pix
);

   // R3: pixel k = {byte k of the first beat, bit pair k of the second}
   for (genvar gi = 0; gi < GROUP; gi++) begin : g_pix
      assign pix[gi*PIX_W +: PIX_W] = {msb_word[gi*BYTE_W +: BYTE_W],
                                       lsb_bits[gi*LSB_W +: LSB_W]};
   end

endmodule

// File: rtl/raw10br_pack.sv
module raw10br_pack #(
   parameter int PPC   = 2,
   parameter int PIX_W = 10,
   parameter int OUT_W = 32,
   localparam int FIELD = PPC * PIX_W
) (
   input  logic [FIELD-1:0] pix,
   output logic [OUT_W-1:0] beat
);

   // R4: bits above the pixel fields are zero
   if (OUT_W > FIELD) begin : g_pad
      assign beat = {{(OUT_W-FIELD){1'b0}}, pix};
   end else begin : g_exact
      assign beat = pix;
   end

endmodule

// File: rtl/raw10_repack_bridge.sv
module raw10_repack_bridge
   import raw10br_pkg::*;
#(
   parameter int IN_W   = 32,
   parameter int OUT_W  = 32,
   parameter int PIX_W  = 10,
   parameter int PPC    = 2,
   parameter int DT_W   = 6,
   parameter bit EXT_VC = 1'b0,
   localparam int VC_W  = EXT_VC ? 4 : 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DT_W-1:0]  cfg_dt,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [IN_W-1:0]  s_data,
   input  logic             s_sop,
   input  logic             s_eop,
   input  logic             s_fs,
   input  logic [DT_W-1:0]  s_dt,
   input  logic [VC_W-1:0]  s_vc,
   output logic             m_tvalid,
   input  logic             m_tready,
   output logic [OUT_W-1:0] m_tdata,
   output logic             m_tuser,
   output logic             m_tlast,
   output logic [DT_W-1:0]  m_tdt,
   output logic [VC_W-1:0]  m_tvc
);

   localparam int BYTE_W = 8;
   localparam int GROUP  = IN_W / BYTE_W;
   localparam int LSB_W  = PIX_W - BYTE_W;
   localparam int FIELD  = PPC * PIX_W;

   // elaboration-time parameter checks
   if (GROUP != 2*PPC) begin : g_chk_group
      $error("raw10_repack_bridge: a group must fill exactly two output beats");
   end
   if (OUT_W < IN_W) begin : g_chk_outw
      $error("raw10_repack_bridge: OUT_W must hold a copied input beat");
   end
   if (OUT_W <= FIELD) begin : g_chk_field
      $error("raw10_repack_bridge: OUT_W must exceed the pixel fields");
   end
   if (PIX_W <= BYTE_W || GROUP*LSB_W > IN_W) begin : g_chk_pix
      $error("raw10_repack_bridge: pixel width does not fit the packed layout");
   end

   mode_e             cls_mode, mode_q, cur_mode;
   logic              phase_q, cur_phase;
   logic [IN_W-1:0]   msb_q;
   logic [DT_W-1:0]   dt_q, cur_dt;
   logic [VC_W-1:0]   vc_q, cur_vc;
   logic              sof_q, sof_now;
   logic              pend_q, pend_last_q;
   logic [OUT_W-1:0]  pend_data_q;
   logic              can_load, fire;
   logic              emit, emit_last, take_pend;
   logic [OUT_W-1:0]  emit_data;
   logic [GROUP*PIX_W-1:0] pix;
   logic [OUT_W-1:0]  half_beat [2];

   raw10br_classify #(.DT_W(DT_W)) u_cls (
      .pkt_dt (s_dt),
      .cfg_dt (cfg_dt),
      .mode   (cls_mode)
   );

   raw10br_unpack #(.GROUP(GROUP), .PIX_W(PIX_W), .BYTE_W(BYTE_W)) u_unpack (
      .msb_word (msb_q),
      .lsb_bits (s_data[GROUP*LSB_W-1:0]),
      .pix      (pix)
   );

   for (genvar gh = 0; gh < 2; gh++) begin : g_half
      raw10br_pack #(.PPC(PPC), .PIX_W(PIX_W), .OUT_W(OUT_W)) u_pack (
         .pix  (pix[gh*FIELD +: FIELD]),
         .beat (half_beat[gh])
      );
   end

   assign can_load  = !m_tvalid || m_tready;
   assign s_ready   = can_load && !pend_q;
   assign fire      = s_valid && s_ready;

   assign cur_mode  = s_sop ? cls_mode : mode_q;
   assign cur_phase = s_sop ? 1'b0 : phase_q;
   assign cur_dt    = s_sop ? s_dt : dt_q;
   assign cur_vc    = s_sop ? s_vc : vc_q;
   assign sof_now   = sof_q || (s_sop && s_fs);

   always_comb begin
      emit      = 1'b0;
      emit_last = 1'b0;
      take_pend = 1'b0;
      emit_data = '0;
      if (fire) begin
         unique case (cur_mode)
            MODE_PASS: begin
               emit      = 1'b1;
               emit_data = OUT_W'(s_data);
               emit_last = s_eop;
            end
            MODE_CONV: begin
               if (!cur_phase) begin
                  // R7: lone MSB beat at end of packet becomes a closing beat
                  emit      = s_eop;
                  emit_last = s_eop;
               end else begin
                  emit      = 1'b1;
                  emit_data = half_beat[0];
                  take_pend = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         m_tvalid    <= 1'b0;
         m_tdata     <= '0;
         m_tuser     <= 1'b0;
         m_tlast     <= 1'b0;
         m_tdt       <= '0;
         m_tvc       <= '0;
         mode_q      <= MODE_DROP;
         phase_q     <= 1'b0;
         msb_q       <= '0;
         dt_q        <= '0;
         vc_q        <= '0;
         sof_q       <= 1'b0;
         pend_q      <= 1'b0;
         pend_last_q <= 1'b0;
         pend_data_q <= '0;
      end else begin
         if (can_load) begin
            if (pend_q) begin
               m_tvalid <= 1'b1;
               m_tdata  <= pend_data_q;
               m_tlast  <= pend_last_q;
               m_tuser  <= 1'b0;
               pend_q   <= 1'b0;
            end else if (emit) begin
               m_tvalid <= 1'b1;
               m_tdata  <= emit_data;
               m_tlast  <= emit_last;
               m_tuser  <= sof_now;
               m_tdt    <= cur_dt;
               m_tvc    <= cur_vc;
            end else begin
               m_tvalid <= 1'b0;
            end
         end
         if (fire) begin
            if (s_sop) begin
               mode_q <= cls_mode;
               dt_q   <= s_dt;
               vc_q   <= s_vc;
            end
            if (emit)
               sof_q <= 1'b0;
            else if (s_sop && s_fs)
               sof_q <= 1'b1;
            phase_q <= (cur_mode == MODE_CONV) && !cur_phase && !s_eop;
            if (!cur_phase)
               msb_q <= s_data;
            if (take_pend) begin
               pend_q      <= 1'b1;
               pend_data_q <= half_beat[1];
               pend_last_q <= s_eop;
            end
         end
      end
   end

endmodule

// File: rtl/raw10br_checker.sv
module raw10br_checker
   import raw10br_pkg::*;
#(
   parameter int OUT_W = 32,
   parameter int DT_W  = 6,
   parameter int FIELD = 20
) (
   input logic             clk,
   input logic             rst,
   input logic [DT_W-1:0]  cfg_dt,
   input logic             s_ready,
   input logic             m_tvalid,
   input logic             m_tready,
   input logic [OUT_W-1:0] m_tdata,
   input logic             m_tuser,
   input logic             m_tlast,
   input logic [DT_W-1:0]  m_tdt,
   input logic             pend
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !m_tvalid && !pend);                                     // R1

   AST_TYPE_FILTER: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |-> (m_tdt == cfg_dt) || (m_tdt == DT_W'(DT_RAW8)) ||
                   ((m_tdt >= DT_W'(DT_USER_LO)) && (m_tdt <= DT_W'(DT_USER_HI)))); // R2

   AST_CONV_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && m_tdt == DT_W'(DT_RAW10) && cfg_dt == DT_W'(DT_RAW10))
      |-> (m_tdata[OUT_W-1:FIELD] == '0));                             // R4

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) &&
                                  $stable(m_tlast) && $stable(m_tuser)); // R10

   AST_PEND_STALLS_INPUT: assert property (@(posedge clk) disable iff (rst)
      pend |-> !s_ready);                                              // R10

   AST_SECOND_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && m_tready && pend) |=> m_tvalid && !m_tuser);        // R8

endmodule

bind raw10_repack_bridge raw10br_checker #(
   .OUT_W (OUT_W),
   .DT_W  (DT_W),
   .FIELD (PPC*PIX_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cfg_dt   (cfg_dt),
   .s_ready  (s_ready),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .m_tdata  (m_tdata),
   .m_tuser  (m_tuser),
   .m_tlast  (m_tlast),
   .m_tdt    (m_tdt),
   .pend     (pend_q)
);

// File: tb/tb_raw10_repack_bridge.sv
module tb_raw10_repack_bridge;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  cfg_dt = 6'h2B;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [31:0] s_data = '0;
   logic        s_sop = 1'b0, s_eop = 1'b0, s_fs = 1'b0;
   logic [5:0]  s_dt = '0;
   logic [1:0]  s_vc = '0;
   logic        m_tvalid, m_tready = 1'b1;
   logic [31:0] m_tdata;
   logic        m_tuser, m_tlast;
   logic [5:0]  m_tdt;
   logic [1:0]  m_tvc;

   raw10_repack_bridge dut (
      .clk(clk), .rst(rst), .cfg_dt(cfg_dt),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .s_sop(s_sop), .s_eop(s_eop), .s_fs(s_fs), .s_dt(s_dt), .s_vc(s_vc),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
      .m_tuser(m_tuser), .m_tlast(m_tlast), .m_tdt(m_tdt), .m_tvc(m_tvc)
   );

   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int failures = 0;
   bit done = 0;
   bit bp_mode = 0;
   bit sof_m = 0;
   logic [7:0] lfsr = 8'h5D;

   logic [31:0] q_data[$];
   logic        q_last[$];
   logic        q_user[$];
   logic [1:0]  q_vc[$];
   logic [5:0]  q_dt[$];
   string       q_tag[$];

   task automatic push_exp(logic [31:0] d, logic l, logic [1:0] vc, logic [5:0] dt, string tag);
      q_data.push_back(d); q_last.push_back(l); q_user.push_back(sof_m);
      q_vc.push_back(vc); q_dt.push_back(dt); q_tag.push_back(tag);
      sof_m = 0;
   endtask

   // monitor: backpressure driver and scoreboard
   always begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_tready = bp_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
      #1;
      if (!rst && m_tvalid && m_tready) begin
         checks++;
         if (q_data.size() == 0) begin
            failures++;
            $display("FAIL R2 unexpected beat data=%h exp=none", m_tdata);
         end else begin
            logic [31:0] d; logic l, u; logic [1:0] vc; logic [5:0] dt; string tag;
            d = q_data.pop_front(); l = q_last.pop_front(); u = q_user.pop_front();
            vc = q_vc.pop_front(); dt = q_dt.pop_front(); tag = q_tag.pop_front();
            if (m_tdata !== d || m_tlast !== l || m_tuser !== u || m_tvc !== vc || m_tdt !== dt) begin
               failures++;
               $display("FAIL %s act data=%h last=%b user=%b vc=%0d dt=%h exp data=%h last=%b user=%b vc=%0d dt=%h",
                        tag, m_tdata, m_tlast, m_tuser, m_tvc, m_tdt, d, l, u, vc, dt);
            end
         end
      end
   end

   task automatic drive_beat(logic [31:0] d, logic sop, logic eop, logic fs, logic [5:0] dt, logic [1:0] vc);
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_sop = sop; s_eop = eop; s_fs = fs; s_dt = dt; s_vc = vc;
      #1;
      while (!s_ready) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic idle_bus();
      @(negedge clk);
      s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_fs = 1'b0;
   endtask

   task automatic drain();
      idle_bus();
      while (q_data.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [9:0] pixv(int seed, int i);
      return 10'(seed * 97 + i * 211 + 5);
   endfunction

   function automatic bit forwarded(logic [5:0] dt);
      return (dt == cfg_dt) || (dt == 6'h2A) || (dt >= 6'h30 && dt <= 6'h37);
   endfunction

   // RAW10 packet: ngroups whole groups, optionally a trailing lone MSB beat
   task automatic send_raw10(int ngroups, bit tail, logic fs, logic [1:0] vc, int seed, string tag);
      if (fs) sof_m = 1;
      for (int g = 0; g < ngroups; g++) begin
         logic [9:0] p0, p1, p2, p3;
         logic last;
         p0 = pixv(seed, 4*g); p1 = pixv(seed, 4*g+1);
         p2 = pixv(seed, 4*g+2); p3 = pixv(seed, 4*g+3);
         last = (g == ngroups-1) && !tail;
         push_exp({12'h0, p1, p0}, 1'b0, vc, 6'h2B, tag);
         push_exp({12'h0, p3, p2}, last, vc, 6'h2B, tag);
         drive_beat({p3[9:2], p2[9:2], p1[9:2], p0[9:2]}, g == 0, 1'b0, fs, 6'h2B, vc);
         drive_beat({24'hA5C3E1, p3[1:0], p2[1:0], p1[1:0], p0[1:0]}, 1'b0, last, fs, 6'h2B, vc);
      end
      if (tail) begin
         push_exp(32'h0, 1'b1, vc, 6'h2B, tag);
         drive_beat(32'hDEADBEEF ^ 32'(seed), ngroups == 0, 1'b1, fs, 6'h2B, vc);
      end
      idle_bus();
   endtask

   task automatic send_copy(logic [5:0] dt, int nbeats, logic fs, logic [1:0] vc, int seed, string tag);
      bit fw;
      fw = forwarded(dt);
      if (fs) sof_m = 1;
      for (int b = 0; b < nbeats; b++) begin
         logic [31:0] w;
         w = 32'(seed) * 32'h9E3779B1 + 32'(b) * 32'h01234567;
         if (fw) push_exp(w, b == nbeats-1, vc, dt, tag);
         drive_beat(w, b == 0, b == nbeats-1, fs, dt, vc);
      end
      idle_bus();
   endtask

   task automatic check_idle(string tag);
      @(negedge clk); #1;
      checks++;
      if (m_tvalid !== 1'b0 || s_ready !== 1'b1) begin
         failures++;
         $display("FAIL %s act tvalid=%b ready=%b exp tvalid=0 ready=1", tag, m_tvalid, s_ready);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check_idle("R1 in reset");
      rst = 1'b0;
      check_idle("R1 after reset");

      // R3 R4 R6 R8 R9: conversion with frame start, two channels
      send_raw10(2, 0, 1'b1, 2'd1, 3, "R3");
      send_raw10(3, 0, 1'b0, 2'd2, 7, "R6");
      // R5: exempt types copied
      send_copy(6'h2A, 3, 1'b0, 2'd3, 11, "R5");
      send_copy(6'h31, 2, 1'b0, 2'd0, 12, "R5");
      // R2 R8: dropped frame-start packet, flag lands on next forwarded beat
      send_copy(6'h24, 2, 1'b1, 2'd1, 13, "R2");
      send_raw10(1, 0, 1'b0, 2'd1, 14, "R8");
      // R2 boundaries of the user window
      send_copy(6'h38, 2, 1'b0, 2'd2, 15, "R2");
      send_copy(6'h37, 1, 1'b0, 2'd2, 16, "R2");
      send_copy(6'h2F, 2, 1'b0, 2'd2, 17, "R2");
      send_copy(6'h2C, 1, 1'b0, 2'd2, 18, "R2");
      // R7: truncated packets
      send_raw10(1, 1, 1'b0, 2'd3, 19, "R7");
      send_raw10(0, 1, 1'b1, 2'd0, 20, "R7");
      drain();

      // R10: random backpressure
      bp_mode = 1;
      send_raw10(4, 0, 1'b1, 2'd2, 21, "R10");
      send_copy(6'h2A, 4, 1'b0, 2'd1, 22, "R10");
      send_raw10(2, 1, 1'b0, 2'd3, 23, "R10");
      drain();
      bp_mode = 0;

      // R5 R2: non-RAW10 configuration
      cfg_dt = 6'h24;
      send_copy(6'h24, 3, 1'b1, 2'd0, 24, "R5");
      send_copy(6'h2B, 2, 1'b0, 2'd1, 25, "R2");
      send_copy(6'h33, 1, 1'b0, 2'd1, 26, "R9");
      drain();

      // R11: reset in the middle of a pair
      cfg_dt = 6'h2B;
      drive_beat(32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 6'h2B, 2'd2);
      idle_bus();
      @(negedge clk);
      rst = 1'b1;
      sof_m = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check_idle("R11 after reset");
      send_raw10(2, 0, 1'b0, 2'd1, 27, "R11");
      drain();

      checks++;
      if (q_data.size() != 0) begin
         failures++;
         $display("FAIL R2 missing beats act=%0d exp=0", q_data.size());
      end
      done = 1;
      finish_run();
   end

endmodule